// File: doc/BRIEF.md
# Two-Wire Pointer-Addressed Register Slave

This block is the bus-facing half of a small sensor-style peripheral. It is a slave on a two-wire serial bus (clock line and open-drain data line). It lets a master reach four 16-bit registers through a 2-bit register pointer. The SCL and SDA inputs are sampled by the system clock. The block drives SDA only through an enable that pulls the line low. The register storage sits outside the block. It is reached through one selector, a read-data input and a write strobe with data.

A transaction begins with START and the address byte, which names this slave. In a write, the next byte is always the pointer. The data bytes that follow go to the selected register: one byte for the configuration register and two bytes for the other three. In a read, the block sends the selected register, most significant byte first. The pointer survives from one transaction to the next, so reads need not resend it. Three reserved values of the byte after the address are passed out as commands. A watchdog frees SDA if the slave itself has held it low for too long.

Top module: `twr_slave`

## Requirements
- R1: After reset the slave leaves SDA released, asserts no write or command strobe, and selects register 0 (temperature).
- R2: A falling SDA while SCL is high is a START. A START while a transfer is in progress restarts the address phase (repeated START). A rising SDA while SCL is high is a STOP, which ends the transfer and leaves SDA released.
- R3: The slave acknowledges an address byte only when its upper seven bits equal binary 1001 followed by strap bits [2:0]. Bit 0 selects read (1) or write (0). After a non-matching address the slave acknowledges nothing until the next START.
- R4: In a write, the first byte after the address is the pointer. Pointer bits [1:0] select 0 temperature, 1 configuration, 2 hysteresis limit, 3 over-temperature limit. A pointer byte whose upper six bits are not zero gets no acknowledge and leaves the pointer unchanged.
- R5: A write to the configuration register (selector 1) takes one data byte. It gives one write strobe with data[15:8] = the byte and data[7:0] = 0. A write to any other register takes two data bytes, MSB first, and gives a single strobe after the second byte. Each data byte is acknowledged.
- R6: The pointer keeps its value across read transactions. Every write transaction treats its first byte after the address as a new pointer.
- R7: A read sends data MSB first, one bit per SCL period. A two-byte register sends bits [15:8] and then, if the master acknowledges, bits [7:0]. The configuration register sends bits [15:8] only and then leaves SDA released, so the master reads 0xFF.
- R8: A master NACK after the first byte of a two-byte read ends the read. The next read starts again at bits [15:8].
- R9: When the byte after a write address is 0xB8 or 0x48, the slave gives a one-cycle command strobe with that code and acknowledges it. For 0x54 it gives the strobe without an acknowledge. None of these bytes changes the pointer.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: Once the slave has held SDA low for TIMEOUT_CYC clock cycles, it releases SDA. It then ignores the bus until the next START or STOP.
- R12: The master holding SDA low, however long, neither starts the timeout nor disturbs the transfer in progress.
- R13: The write strobe and the command strobe each last exactly one clock cycle per event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Low three bits of the slave address |
| reg_sel_o | output | 2 | Register selector (current pointer) for reads and writes |
| reg_rd_data_i | input | 16 | Contents of the selected register |
| reg_wr_o | output | 1 | One-cycle write strobe |
| reg_wr_data_o | output | 16 | Data for the selected register on a write strobe |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| cmd_code_o | output | 8 | Command byte that went with the last strobe |

## Verification
A wrong byte counter or a wrong phase state shows up at once as a missing or misplaced acknowledge. It can also show as a data bit shifted by one position. Either appears within the same nine-clock byte. A pointer that was corrupted or updated by mistake appears only at the next read, as data from the wrong register. For that reason, reads follow every pointer-changing or pointer-preserving operation. A stuck drive state is caught by the hold watchdog after TIMEOUT_CYC cycles, and the bench measures that window from both sides.

// File: rtl/twr_pkg.sv
package twr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RACK,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } twr_state_e;

    typedef enum logic [1:0] {
        BY_ADDR,
        BY_PTR,
        BY_DATA
    } twr_byte_e;

    typedef enum logic [1:0] {
        NX_PTR,
        NX_DATA,
        NX_SEND,
        NX_HALT
    } twr_next_e;

    localparam logic [3:0] DEV_PREFIX  = 4'b1001;
    localparam logic [1:0] SEL_CFG     = 2'b01;
    localparam logic [7:0] CMD_RECALL  = 8'hB8;
    localparam logic [7:0] CMD_STORE   = 8'h48;
    localparam logic [7:0] CMD_RESTART = 8'h54;

    typedef struct packed {
        twr_state_e  st;
        twr_byte_e   kind;
        twr_next_e   nxt;
        logic [2:0]  cnt;
        logic [7:0]  sh;
        logic        full;
        logic        mack;
        logic [1:0]  ptr;
        logic        bidx;
        logic [7:0]  wbuf;
        logic [7:0]  tx;
        logic        oe;
        logic        wr;
        logic [15:0] wdata;
        logic        cmd_v;
        logic [7:0]  cmd;
    } twr_core_s;

endpackage

// File: rtl/twr_line_sync.sv
module twr_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    localparam int PW = STAGES + 1;

    logic [PW-1:0] scl_d, scl_q, sda_d, sda_q;
    logic scl_old, sda_old;

    always_comb begin
        scl_d = {scl_q[PW-2:0], scl_i};
        sda_d = {sda_q[PW-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_o   = scl_q[PW-2];
    assign sda_o   = sda_q[PW-2];
    assign scl_old = scl_q[PW-1];
    assign sda_old = sda_q[PW-1];

    assign rise_o  = scl_o & ~scl_old;
    assign fall_o  = ~scl_o & scl_old;
    assign start_o = scl_o & scl_old & sda_old & ~sda_o;
    assign stop_o  = scl_o & scl_old & ~sda_old & sda_o;

endmodule

// File: rtl/twr_hold_watchdog.sv
module twr_hold_watchdog #(
    parameter int LIMIT = 1000000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_i,
    output logic expire_o
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          exp_d, exp_q;

    always_comb begin
        exp_d = 1'b0;
        if (!drive_i || exp_q) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(LIMIT - 1)) begin
            cnt_d = '0;
            exp_d = 1'b1;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            exp_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            exp_q <= exp_d;
        end
    end

    assign expire_o = exp_q;

    // Expiry only follows a cycle in which the slave was driving SDA.
    assert_expire_needs_drive_R12: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |-> $past(drive_i));

    // Expiry is a single-cycle event.
    assert_expire_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        expire_o |=> !expire_o);

endmodule

// File: rtl/twr_slave.sv
module twr_slave #(
    parameter int TIMEOUT_CYC = 1000000,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [2:0]  strap_i,
    output logic [1:0]  reg_sel_o,
    input  logic [15:0] reg_rd_data_i,
    output logic        reg_wr_o,
    output logic [15:0] reg_wr_data_o,
    output logic        cmd_valid_o,
    output logic [7:0]  cmd_code_o
);
    import twr_pkg::*;

    twr_core_s q, d;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop, tmo;
    logic [7:0] rx_byte;
    logic       wide_reg;
    logic       is_cmd;

    twr_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_i),
        .sda_i   (sda_i),
        .scl_o   (scl_s),
        .sda_o   (sda_s),
        .rise_o  (scl_rise),
        .fall_o  (scl_fall),
        .start_o (bus_start),
        .stop_o  (bus_stop)
    );

    twr_hold_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
        .clk      (clk),
        .rst_n    (rst_n),
        .drive_i  (q.oe),
        .expire_o (tmo)
    );

    assign rx_byte  = q.sh;
    assign wide_reg = (q.ptr != SEL_CFG);
    assign is_cmd   = (rx_byte == CMD_RECALL) || (rx_byte == CMD_STORE) ||
                      (rx_byte == CMD_RESTART);

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        d.cmd_v = 1'b0;
        if (tmo) begin
            d.st = ST_WAIT;
            d.oe = 1'b0;
        end else if (bus_start) begin
            d.st   = ST_RX;
            d.kind = BY_ADDR;
            d.cnt  = '0;
            d.full = 1'b0;
            d.oe   = 1'b0;
        end else if (bus_stop) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else begin
            case (q.st)
                ST_RX: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 3'd1;
                        if (q.cnt == 3'd7) d.full = 1'b1;
                    end else if (scl_fall && q.full) begin
                        d.full = 1'b0;
                        d.cnt  = '0;
                        d.st   = ST_RACK;
                        d.oe   = 1'b1;
                        case (q.kind)
                            BY_ADDR: begin
                                if (rx_byte[7:1] != {DEV_PREFIX, strap_i}) begin
                                    d.st = ST_WAIT;
                                    d.oe = 1'b0;
                                end else begin
                                    d.nxt  = rx_byte[0] ? NX_SEND : NX_PTR;
                                    d.bidx = 1'b0;
                                end
                            end
                            BY_PTR: begin
                                if (is_cmd) begin
                                    d.cmd_v = 1'b1;
                                    d.cmd   = rx_byte;
                                    d.nxt   = NX_HALT;
                                    if (rx_byte == CMD_RESTART) begin
                                        d.st = ST_WAIT;
                                        d.oe = 1'b0;
                                    end
                                end else if (rx_byte[7:2] == 6'd0) begin
                                    d.ptr  = rx_byte[1:0];
                                    d.nxt  = NX_DATA;
                                    d.bidx = 1'b0;
                                end else begin
                                    d.st = ST_WAIT;
                                    d.oe = 1'b0;
                                end
                            end
                            default: begin
                                if (wide_reg && !q.bidx) begin
                                    d.wbuf = rx_byte;
                                    d.bidx = 1'b1;
                                    d.nxt  = NX_DATA;
                                end else begin
                                    d.wr    = 1'b1;
                                    d.wdata = wide_reg ? {q.wbuf, rx_byte} : {rx_byte, 8'h00};
                                    d.nxt   = NX_HALT;
                                end
                            end
                        endcase
                    end
                end
                ST_RACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.cnt = '0;
                        case (q.nxt)
                            NX_PTR:  begin d.st = ST_RX; d.kind = BY_PTR;  end
                            NX_DATA: begin d.st = ST_RX; d.kind = BY_DATA; end
                            NX_SEND: begin
                                d.st = ST_TX;
                                d.tx = reg_rd_data_i[15:8];
                                d.oe = ~reg_rd_data_i[15];
                            end
                            default: d.st = ST_WAIT;
                        endcase
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (q.cnt == 3'd7) begin
                            d.st = ST_MACK;
                            d.oe = 1'b0;
                        end else begin
                            d.cnt = q.cnt + 3'd1;
                            d.tx  = {q.tx[6:0], 1'b0};
                            d.oe  = ~q.tx[6];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.mack && wide_reg && !q.bidx) begin
                            d.bidx = 1'b1;
                            d.cnt  = '0;
                            d.st   = ST_TX;
                            d.tx   = reg_rd_data_i[7:0];
                            d.oe   = ~reg_rd_data_i[7];
                        end else begin
                            d.st = ST_WAIT;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o      = q.oe;
    assign reg_sel_o     = q.ptr;
    assign reg_wr_o      = q.wr;
    assign reg_wr_data_o = q.wdata;
    assign cmd_valid_o   = q.cmd_v;
    assign cmd_code_o    = q.cmd;

    // Drive changes are decided only while the synchronised clock is low.
    assert_sda_moves_low_scl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((q.oe != $past(q.oe)) && !$past(tmo)) |-> !$past(scl_s));

    assert_wr_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o);

    assert_cmd_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    assert_restart_cmd_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && cmd_code_o == CMD_RESTART) |=> !sda_oe_o);

    assert_idle_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE || q.st == ST_WAIT) |-> !sda_oe_o);

endmodule

// File: tb/tb_twr_slave.sv
`timescale 1ns/1ps
module tb_twr_slave;
    localparam int TMO = 600;
    localparam int Q   = 8;
    localparam logic [7:0] AW = 8'h9A;
    localparam logic [7:0] AR = 8'h9B;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_low = 1'b0;
    logic [2:0] strap = 3'b101;
    logic sda_oe, reg_wr, cmd_valid;
    logic [1:0] reg_sel;
    logic [15:0] rd_data, wr_data;
    logic [7:0] cmd_code;
    logic sda_bus;
    logic [15:0] rf [4];

    int total = 0, bad = 0;
    int wr_cnt = 0, cmd_cnt = 0, viol = 0, run = 0, max_run = 0;
    logic [1:0]  last_idx;
    logic [15:0] last_wdata;
    logic [7:0]  last_cmd;
    logic prev_oe = 1'b0;

    always #5 clk = ~clk;

    assign sda_bus = !(m_low || sda_oe);
    assign rd_data = rf[reg_sel];

    twr_slave #(.TIMEOUT_CYC(TMO), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .strap_i(strap), .reg_sel_o(reg_sel), .reg_rd_data_i(rd_data),
        .reg_wr_o(reg_wr), .reg_wr_data_o(wr_data),
        .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            rf[0] <= 16'hE6F0; rf[1] <= 16'h3C00; rf[2] <= 16'h4B00; rf[3] <= 16'h5000;
        end else begin
            if (reg_wr) begin
                rf[reg_sel] <= wr_data;
                wr_cnt     <= wr_cnt + 1;
                last_idx   <= reg_sel;
                last_wdata <= wr_data;
            end
            if (cmd_valid) begin
                cmd_cnt  <= cmd_cnt + 1;
                last_cmd <= cmd_code;
            end
            run <= (reg_wr || cmd_valid) ? run + 1 : 0;
            if (run > max_run) max_run <= run;
        end
    end

    always @(negedge clk) begin
        if (rst_n && (sda_oe != prev_oe) && m_scl) viol <= viol + 1;
        prev_oe <= sda_oe;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic clk_bit(input logic b, output logic smp);
        m_low = !b; tick(Q);
        m_scl = 1'b1; tick(Q);
        smp = sda_bus; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
        clk_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] v);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clk_bit(1'b1, s);
            v[i] = s;
        end
        clk_bit(!give_ack, s);
    endtask

    task automatic do_read(input int n, output logic [15:0] v);
        logic a;
        logic [7:0] hi, lo;
        lo = 8'h00;
        bus_start();
        wr_byte(AR, a);
        rd_byte(n == 2, hi);
        if (n == 2) rd_byte(1'b0, lo);
        bus_stop();
        v = {hi, lo};
    endtask

    task automatic set_ptr(input logic [7:0] p, output logic ack);
        logic a;
        bus_start();
        wr_byte(AW, a);
        wr_byte(p, ack);
        bus_stop();
    endtask

    initial begin
        logic a, a2, a3;
        logic [15:0] v;
        logic [7:0] b1, b2;
        int w0, c0;

        tick(5);
        rst_n = 1'b1;
        tick(2);
        chk("R1 sda released", sda_oe, 0);
        chk("R1 selector", reg_sel, 0);
        chk("R1 wr strobe", reg_wr, 0);
        chk("R1 cmd strobe", cmd_valid, 0);

        // R3: every strap against every low address field
        for (int s = 0; s < 8; s++) begin
            for (int lo = 0; lo < 8; lo++) begin
                strap = 3'(s);
                bus_start();
                wr_byte({4'b1001, 3'(lo), 1'b0}, a);
                bus_stop();
                chk("R3 address match", a, (s == lo));
            end
        end
        strap = 3'b101;
        foreach (b1[i]) ;
        for (int p = 0; p < 4; p++) begin
            logic [3:0] pre;
            pre = (p == 0) ? 4'b0001 : (p == 1) ? 4'b1101 : (p == 2) ? 4'b1000 : 4'b1011;
            bus_start();
            wr_byte({pre, 3'b101, 1'b0}, a);
            wr_byte(8'h00, a2);
            bus_stop();
            chk("R3 wrong prefix nack", a, 0);
            chk("R3 ignored after mismatch", a2, 0);
        end

        // R7/R1: pointer starts at temperature
        do_read(2, v);
        chk("R7 temp read", v, 16'hE6F0);

        // R5: one-byte config write
        w0 = wr_cnt;
        bus_start();
        wr_byte(AW, a); wr_byte(8'h01, a2); wr_byte(8'hA5, a3);
        bus_stop();
        chk("R5 acks", {a, a2, a3}, 3'b111);
        chk("R5 one strobe", wr_cnt - w0, 1);
        chk("R5 cfg idx", last_idx, 1);
        chk("R5 cfg data", last_wdata, 16'hA500);

        // R5: two-byte write with a single strobe after the second byte
        w0 = wr_cnt;
        bus_start();
        wr_byte(AW, a); wr_byte(8'h03, a2); wr_byte(8'h12, a3);
        chk("R5 no strobe after first byte", wr_cnt - w0, 0);
        wr_byte(8'h34, a);
        bus_stop();
        chk("R5 second byte ack", a, 1);
        chk("R5 two-byte strobe", wr_cnt - w0, 1);
        chk("R5 limit idx", last_idx, 3);
        chk("R5 limit data", last_wdata, 16'h1234);

        // R6: pointer persists across reads
        do_read(2, v);
        chk("R6 read 1", v, 16'h1234);
        do_read(2, v);
        chk("R6 read 2", v, 16'h1234);

        // R6: first byte after a write address is always the pointer
        bus_start();
        wr_byte(AW, a); wr_byte(8'h02, a2); wr_byte(8'h4C, a3); wr_byte(8'h80, a);
        bus_stop();
        chk("R6 pointer resent idx", last_idx, 2);
        chk("R6 pointer resent data", last_wdata, 16'h4C80);

        // R4: bad pointer byte gets nack, pointer unchanged
        set_ptr(8'h06, a);
        chk("R4 bad pointer nack", a, 0);
        do_read(2, v);
        chk("R4 pointer unchanged", v, 16'h4C80);

        // R7: configuration read is one byte, then released
        set_ptr(8'h01, a);
        chk("R4 pointer ack", a, 1);
        bus_start();
        wr_byte(AR, a);
        rd_byte(1'b1, b1);
        rd_byte(1'b0, b2);
        bus_stop();
        chk("R7 cfg byte", b1, 8'hA5);
        chk("R7 cfg released after", b2, 8'hFF);

        // R8: early nack ends read, next read restarts high byte
        set_ptr(8'h00, a);
        do_read(1, v);
        chk("R8 early nack byte", v[15:8], 8'hE6);
        do_read(2, v);
        chk("R8 restart high", v, 16'hE6F0);

        // R2: repeated START into a read
        bus_start();
        wr_byte(AW, a); wr_byte(8'h03, a2);
        bus_start();
        wr_byte(AR, a3);
        rd_byte(1'b1, b1); rd_byte(1'b0, b2);
        bus_stop();
        chk("R2 repeated start ack", a3, 1);
        chk("R2 repeated start data", {b1, b2}, 16'h1234);
        chk("R2 released after stop", sda_oe, 0);

        // R9: command bytes
        c0 = cmd_cnt;
        set_ptr(8'hB8, a);
        chk("R9 recall ack", a, 1);
        chk("R9 recall code", last_cmd, 8'hB8);
        set_ptr(8'h48, a);
        chk("R9 store ack", a, 1);
        chk("R9 store code", last_cmd, 8'h48);
        set_ptr(8'h54, a);
        chk("R9 restart no ack", a, 0);
        chk("R9 restart code", last_cmd, 8'h54);
        chk("R9 command count", cmd_cnt - c0, 3);
        do_read(2, v);
        chk("R9 pointer kept", v, 16'h1234);

        // R11: slave hold timeout
        bus_start();
        for (int i = 7; i >= 0; i--) clk_bit(AW[i], a);
        m_low = 1'b0;
        tick(300);
        chk("R11 still held before limit", sda_oe, 1);
        tick(400);
        chk("R11 released after limit", sda_oe, 0);
        bus_stop();
        do_read(2, v);
        chk("R11 recovery read", v, 16'h1234);

        // R12: master holding SDA low does not reset the interface
        bus_start();
        wr_byte(AW, a);
        m_low = 1'b1;
        tick(3 * TMO);
        chk("R12 slave not driving", sda_oe, 0);
        wr_byte(8'h00, a2);
        bus_stop();
        chk("R12 transfer continues", a2, 1);
        do_read(2, v);
        chk("R12 pointer applied", v, 16'hE6F0);

        chk("R10 drive changes with SCL high", viol, 0);
        chk("R13 strobe width", max_run, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule